// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block gives two ports, each on its own clock, a side channel for short command words that bypasses the data queues between them. One register carries a word from the A side to the B side, and the other carries a word from B to A. Each register has an active-low "mail pending" flag in the sender's clock domain. The flag goes low when the sender deposits a word. It returns high once the receiver has read the word and that read has crossed back into the sender's domain.

Each port has a mailbox-select input. When it is high, a write on that port targets the outgoing mail register and the port's read data comes from the incoming mail register. When it is low, the port's read data passes through the queue output supplied from outside. Reads leave the register contents untouched. A second write is refused while a word is still pending.

A bus-size setting picks how many low-order data bits the mailboxes carry: 36, 18 or 9. Bits above the active width are never stored and always read as zero. Completion events cross clock domains as level toggles through a two-flop synchronizer. A port must not issue two mailbox reads faster than the other clock can sample the toggle.

Top module: `mbox_pair`

## Requirements
- R1: After reset both flags `mbf1_no` and `mbf2_no` are high, and both mail registers hold zero, which reads as zero on `b_rdata_o` and `a_rdata_o` with mailbox select high.
- R2: A rising `clk_a_i` edge with `a_wr_i` and `a_mbx_sel_i` high while `mbf1_no` is high stores `a_wdata_i` in the A-to-B register and drives `mbf1_no` low after that edge. With `b_mbx_sel_i` high, `b_rdata_o` then shows the stored word.
- R3: A rising `clk_b_i` edge with `b_wr_i` and `b_mbx_sel_i` high while `mbf2_no` is high stores `b_wdata_i` in the B-to-A register and drives `mbf2_no` low. With `a_mbx_sel_i` high, `a_rdata_o` then shows the stored word.
- R4: A mailbox write while that register's flag is low is ignored: the stored word and the flag are unchanged.
- R5: A B-side mailbox read (`b_rd_i` and `b_mbx_sel_i` high at a `clk_b_i` edge) returns `mbf1_no` high. The flag changes no earlier than the third `clk_a_i` edge after the read and no later than the fifth.
- R6: An A-side mailbox read (`a_rd_i` and `a_mbx_sel_i` high at a `clk_a_i` edge) returns `mbf2_no` high. The flag changes no earlier than the third `clk_b_i` edge after the read and no later than the fifth.
- R7: A read does not alter a mail register. Its contents change only on an accepted write.
- R8: `bus_size_i` encodes 2'b00 = 36 bits, 2'b01 = 18 bits (bits [17:0]), 2'b10 or 2'b11 = 9 bits (bits [8:0]). Write bits above the active width are discarded, and mailbox read data above the active width is zero.
- R9: With a port's mailbox select low, its read data equals that port's queue input (`a_fifo_q_i` or `b_fifo_q_i`).
- R10: A write with mailbox select low changes neither the mail register nor its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_size_i | input | 2 | Active mailbox width: 00=36, 01=18, 1x=9 |
| a_wr_i | input | 1 | Port A write enable |
| a_rd_i | input | 1 | Port A read enable |
| a_mbx_sel_i | input | 1 | Port A mailbox select |
| a_wdata_i | input | 36 | Port A write data |
| a_fifo_q_i | input | 36 | Queue output shown on port A when select is low |
| a_rdata_o | output | 36 | Port A read data |
| b_wr_i | input | 1 | Port B write enable |
| b_rd_i | input | 1 | Port B read enable |
| b_mbx_sel_i | input | 1 | Port B mailbox select |
| b_wdata_i | input | 36 | Port B write data |
| b_fifo_q_i | input | 36 | Queue output shown on port B when select is low |
| b_rdata_o | output | 36 | Port B read data |
| mbf1_no | output | 1 | A-to-B mail pending, active low, `clk_a_i` domain |
| mbf2_no | output | 1 | B-to-A mail pending, active low, `clk_b_i` domain |

## Verification
The bench sends a second word while mail is still pending and confirms that the receiver still sees the first word. A design without the lockout would show the overwriting word. After a read, the bench samples the sender's flag right away and again after the synchronization window. A flag set directly from the other clock, or a lost toggle, shows up as an early rise or a flag stuck low. Random data with all three bus sizes exposes upper bits that leak through on store or on read. Writes with select low, and reads with select low, catch mail that is corrupted by queue traffic or a read mux that is inverted.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MBOX_W = 36;
  localparam int HALF_W = 18;
  localparam int BYTE_W = 9;

  typedef enum logic [1:0] {
    BUS_FULL = 2'b00,
    BUS_HALF = 2'b01,
    BUS_BYTE = 2'b10,
    BUS_BYTE_ALT = 2'b11
  } bus_size_e;

  function automatic logic [MBOX_W-1:0] lane_mask(bus_size_e s);
    case (s)
      BUS_FULL: lane_mask = {MBOX_W{1'b1}};
      BUS_HALF: lane_mask = {{(MBOX_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default:  lane_mask = {{(MBOX_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    endcase
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
// One direction: register and flag in the sender domain, read toggle in the receiver domain.
module mbox_channel #(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_s_i,
  input  logic         clk_r_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  input  logic         rd_i,
  output logic         flag_no,
  output logic [W-1:0] mail_o
);
  logic [W-1:0] mail_q;
  logic         flag_q;
  logic         rd_tgl_q;
  logic         rd_tgl_s;
  logic         rd_prev_q;
  logic         rd_evt;
  logic         accept;

  // receiver domain: each read flips a level
  always_ff @(posedge clk_r_i or negedge rst_ni)
    if (!rst_ni)   rd_tgl_q <= 1'b0;
    else if (rd_i) rd_tgl_q <= ~rd_tgl_q;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_s_i),
    .rst_ni (rst_ni),
    .d_i    (rd_tgl_q),
    .q_o    (rd_tgl_s)
  );

  always_ff @(posedge clk_s_i or negedge rst_ni)
    if (!rst_ni) rd_prev_q <= 1'b0;
    else         rd_prev_q <= rd_tgl_s;

  assign rd_evt = rd_tgl_s ^ rd_prev_q;
  assign accept = wr_i & flag_q;

  // write wins over a read event landing in the same cycle
  always_ff @(posedge clk_s_i or negedge rst_ni)
    if (!rst_ni) begin
      mail_q <= '0;
      flag_q <= 1'b1;
    end else if (accept) begin
      mail_q <= wdata_i & wmask_i;
      flag_q <= 1'b0;
    end else if (rd_evt) begin
      flag_q <= 1'b1;
    end

  assign flag_no = flag_q;
  assign mail_o  = mail_q;
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_size_i,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic              a_mbx_sel_i,
  input  logic [MBOX_W-1:0] a_wdata_i,
  input  logic [MBOX_W-1:0] a_fifo_q_i,
  output logic [MBOX_W-1:0] a_rdata_o,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  input  logic              b_mbx_sel_i,
  input  logic [MBOX_W-1:0] b_wdata_i,
  input  logic [MBOX_W-1:0] b_fifo_q_i,
  output logic [MBOX_W-1:0] b_rdata_o,
  output logic              mbf1_no,
  output logic              mbf2_no
);
  logic [MBOX_W-1:0] mask_w;
  logic [MBOX_W-1:0] mail1_q;
  logic [MBOX_W-1:0] mail2_q;

  assign mask_w = lane_mask(bus_size_e'(bus_size_i));

  mbox_channel #(.W(MBOX_W), .SYNC_STAGES(SYNC_STAGES)) u_a2b (
    .clk_s_i (clk_a_i),
    .clk_r_i (clk_b_i),
    .rst_ni  (rst_ni),
    .wr_i    (a_wr_i & a_mbx_sel_i),
    .wdata_i (a_wdata_i),
    .wmask_i (mask_w),
    .rd_i    (b_rd_i & b_mbx_sel_i),
    .flag_no (mbf1_no),
    .mail_o  (mail1_q)
  );

  mbox_channel #(.W(MBOX_W), .SYNC_STAGES(SYNC_STAGES)) u_b2a (
    .clk_s_i (clk_b_i),
    .clk_r_i (clk_a_i),
    .rst_ni  (rst_ni),
    .wr_i    (b_wr_i & b_mbx_sel_i),
    .wdata_i (b_wdata_i),
    .wmask_i (mask_w),
    .rd_i    (a_rd_i & a_mbx_sel_i),
    .flag_no (mbf2_no),
    .mail_o  (mail2_q)
  );

  // mail data is held stable while pending, so sampling it across domains is safe
  assign b_rdata_o = b_mbx_sel_i ? (mail1_q & mask_w) : b_fifo_q_i;
  assign a_rdata_o = a_mbx_sel_i ? (mail2_q & mask_w) : a_fifo_q_i;
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk
  import mbox_pkg::*;
(
  input logic              clk_a_i,
  input logic              clk_b_i,
  input logic              rst_ni,
  input logic [1:0]        bus_size_i,
  input logic              a_wr_i,
  input logic              a_mbx_sel_i,
  input logic              b_wr_i,
  input logic              b_mbx_sel_i,
  input logic              mbf1_no,
  input logic              mbf2_no,
  input logic [MBOX_W-1:0] mail1_q,
  input logic [MBOX_W-1:0] mail2_q
);
  assert_mail1_take_R2: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_wr_i && a_mbx_sel_i && mbf1_no) |=> !mbf1_no);

  assert_mail2_take_R3: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_wr_i && b_mbx_sel_i && mbf2_no) |=> !mbf2_no);

  assert_mail1_locked_R4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_wr_i && a_mbx_sel_i && !mbf1_no) |=> ($stable(mail1_q) && !mbf1_no));

  assert_mail2_locked_R4: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_wr_i && b_mbx_sel_i && !mbf2_no) |=> ($stable(mail2_q) && !mbf2_no));

  assert_mail1_hold_R7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(a_wr_i && a_mbx_sel_i && mbf1_no) |=> $stable(mail1_q));

  assert_mail2_hold_R7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !(b_wr_i && b_mbx_sel_i && mbf2_no) |=> $stable(mail2_q));

  assert_mail1_trim_R8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_wr_i && a_mbx_sel_i && mbf1_no && bus_size_i != 2'b00)
      |=> (mail1_q[MBOX_W-1:HALF_W] == '0));

  assert_mail2_trim_R8: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_wr_i && b_mbx_sel_i && mbf2_no && bus_size_i != 2'b00)
      |=> (mail2_q[MBOX_W-1:HALF_W] == '0));
endmodule

bind mbox_pair mbox_pair_chk u_chk (
  .clk_a_i     (clk_a_i),
  .clk_b_i     (clk_b_i),
  .rst_ni      (rst_ni),
  .bus_size_i  (bus_size_i),
  .a_wr_i      (a_wr_i),
  .a_mbx_sel_i (a_mbx_sel_i),
  .b_wr_i      (b_wr_i),
  .b_mbx_sel_i (b_mbx_sel_i),
  .mbf1_no     (mbf1_no),
  .mbf2_no     (mbf2_no),
  .mail1_q     (mail1_q),
  .mail2_q     (mail2_q)
);

// File: tb/mbox_pair_tb.sv
module mbox_pair_tb;
  logic        clk_a = 1'b0;
  logic        clk_b = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic        a_wr = 1'b0, a_rd = 1'b0, a_sel = 1'b0;
  logic        b_wr = 1'b0, b_rd = 1'b0, b_sel = 1'b0;
  logic [35:0] a_wdata = '0, a_fifo = '0, b_wdata = '0, b_fifo = '0;
  logic [35:0] a_rdata, b_rdata;
  logic        mbf1_n, mbf2_n;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk_a = ~clk_a;  // 50 MHz
  always #15 clk_b = ~clk_b;  // unrelated second clock

  mbox_pair u_dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n), .bus_size_i(bus_size),
    .a_wr_i(a_wr), .a_rd_i(a_rd), .a_mbx_sel_i(a_sel), .a_wdata_i(a_wdata),
    .a_fifo_q_i(a_fifo), .a_rdata_o(a_rdata),
    .b_wr_i(b_wr), .b_rd_i(b_rd), .b_mbx_sel_i(b_sel), .b_wdata_i(b_wdata),
    .b_fifo_q_i(b_fifo), .b_rdata_o(b_rdata),
    .mbf1_no(mbf1_n), .mbf2_no(mbf2_n)
  );

  function automatic logic [35:0] exp_word(logic [1:0] sz, logic [35:0] d);
    if (sz == 2'b00)      return d;
    else if (sz == 2'b01) return d & 36'h0_0003_FFFF;
    else                  return d & 36'h0_0000_01FF;
  endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom_range(15, 0), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // A -> B transfer; second word must be refused; B read returns flag after sync
  task automatic run_a2b(input logic [1:0] sz, input logic [35:0] d, input logic [35:0] d2);
    logic [35:0] e;
    e = exp_word(sz, d);
    @(negedge clk_a); bus_size = sz; a_wr = 1; a_sel = 1; a_wdata = d;
    @(negedge clk_a); a_wdata = d2;
    chk(mbf1_n == 1'b0, "R2 flag1 low after write", {35'd0, mbf1_n}, 36'd0);
    @(negedge clk_a); a_wr = 0; a_sel = 0;
    chk(mbf1_n == 1'b0, "R4 flag1 stays low", {35'd0, mbf1_n}, 36'd0);
    @(negedge clk_b); b_sel = 1;
    #1 chk(b_rdata == e, "R2/R4/R8 mail1 data", b_rdata, e);
    b_rd = 1;
    @(negedge clk_b); b_rd = 0;
    #1 chk(b_rdata == e, "R7 mail1 kept after read", b_rdata, e);
    b_sel = 0; b_fifo = rnd36();
    #1 chk(b_rdata == b_fifo, "R9 port B queue path", b_rdata, b_fifo);
    @(negedge clk_a);
    chk(mbf1_n == 1'b0, "R5 flag1 not early", {35'd0, mbf1_n}, 36'd0);
    repeat (5) @(negedge clk_a);
    chk(mbf1_n == 1'b1, "R5 flag1 released", {35'd0, mbf1_n}, 36'd1);
    // queue write must not disturb mail
    a_wr = 1; a_sel = 0; a_wdata = ~d;
    @(negedge clk_a); a_wr = 0;
    chk(mbf1_n == 1'b1, "R10 flag1 untouched", {35'd0, mbf1_n}, 36'd1);
    @(negedge clk_b); b_sel = 1;
    #1 chk(b_rdata == e, "R10 mail1 untouched", b_rdata, e);
    b_sel = 0;
  endtask

  task automatic run_b2a(input logic [1:0] sz, input logic [35:0] d, input logic [35:0] d2);
    logic [35:0] e;
    e = exp_word(sz, d);
    @(negedge clk_b); bus_size = sz; b_wr = 1; b_sel = 1; b_wdata = d;
    @(negedge clk_b); b_wdata = d2;
    chk(mbf2_n == 1'b0, "R3 flag2 low after write", {35'd0, mbf2_n}, 36'd0);
    @(negedge clk_b); b_wr = 0; b_sel = 0;
    chk(mbf2_n == 1'b0, "R4 flag2 stays low", {35'd0, mbf2_n}, 36'd0);
    @(negedge clk_a); a_sel = 1;
    #1 chk(a_rdata == e, "R3/R4/R8 mail2 data", a_rdata, e);
    a_rd = 1;
    @(negedge clk_a); a_rd = 0;
    #1 chk(a_rdata == e, "R7 mail2 kept after read", a_rdata, e);
    a_sel = 0; a_fifo = rnd36();
    #1 chk(a_rdata == a_fifo, "R9 port A queue path", a_rdata, a_fifo);
    @(negedge clk_b);
    chk(mbf2_n == 1'b0, "R6 flag2 not early", {35'd0, mbf2_n}, 36'd0);
    repeat (5) @(negedge clk_b);
    chk(mbf2_n == 1'b1, "R6 flag2 released", {35'd0, mbf2_n}, 36'd1);
    b_wr = 1; b_sel = 0; b_wdata = ~d;
    @(negedge clk_b); b_wr = 0;
    chk(mbf2_n == 1'b1, "R10 flag2 untouched", {35'd0, mbf2_n}, 36'd1);
    @(negedge clk_a); a_sel = 1;
    #1 chk(a_rdata == e, "R10 mail2 untouched", a_rdata, e);
    a_sel = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_b);
    // R1 reset state
    chk(mbf1_n == 1'b1, "R1 flag1 reset", {35'd0, mbf1_n}, 36'd1);
    chk(mbf2_n == 1'b1, "R1 flag2 reset", {35'd0, mbf2_n}, 36'd1);
    a_sel = 1; b_sel = 1;
    #1 chk(a_rdata == '0, "R1 mail2 reset", a_rdata, '0);
    chk(b_rdata == '0, "R1 mail1 reset", b_rdata, '0);
    a_sel = 0; b_sel = 0;
    // directed widths with all ones (R8)
    for (int s = 0; s < 4; s++) begin
      run_a2b(s[1:0], 36'hF_FFFF_FFFF, 36'h0_0000_0000);
      run_b2a(s[1:0], 36'hF_FFFF_FFFF, 36'h0_0000_0000);
    end
    // random traffic
    for (int i = 0; i < 12; i++) begin
      run_a2b(2'($urandom_range(3, 0)), rnd36(), rnd36());
      run_b2a(2'($urandom_range(3, 0)), rnd36(), rnd36());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_a);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule